// File: doc/BRIEF.md
# Half-Word SRAM Word Slave with Countdown Ready

This block serves 32-bit word reads and writes from a single on-chip master out of an asynchronous SRAM that is only 16 bits wide. The master gives a command as a one-cycle read or write strobe, with the word address and the write data valid in that same cycle only. The slave keeps its own copy of everything it needs. It then runs two half-word SRAM accesses in a row: the lower half first, then the upper half.

The slave does not answer with a single acknowledge. It shows a 2-bit countdown of the cycles that remain until the word is complete. A fixed pipeline level, set by a parameter, tells the master how early it may send the next command. At level 2, a command sent while the count reads 1 starts right after the current access finishes, with no idle cycle in between. The word that was read stays on the read-data output until the next read request replaces it.

Every SRAM-facing output comes straight from a flip-flop. Read data is captured from the SRAM pins directly into the read-data register. Neither of these adds a cycle to the handshake.

Top module: `sram16_word_slave`

## Requirements
- R1: During and after reset, `rdy_cnt` is 0, `proto_err` is 0, `ram_ce_n`, `ram_oe_n` and `ram_we_n` are high, and `ram_dq_oe` is low.
- R2: A read of word address A fetches SRAM half-word address 2A into `rd_data[15:0]` and half-word address 2A+1 into `rd_data[31:16]`. `rd_data` holds the full word once `rdy_cnt` reads 0, which is 2*WAIT_CYC cycles after the clock edge that took the strobe.
- R3: A write of word address A stores `cmd_wdata[15:0]` at half-word address 2A and `cmd_wdata[31:16]` at 2A+1. Each half holds `ram_we_n` low for WAIT_CYC cycles, with one cycle of `ram_we_n` high between the halves. The write takes 2*WAIT_CYC+1 cycles.
- R4: `rdy_cnt` shows the number of cycles still outstanding, saturated at 3. Once the value is below 3 it falls by exactly one per cycle and stays at 0 when nothing is pending.
- R5: The address and write data only need to be valid in the strobe cycle. The result is correct whatever the master drives on them afterwards.
- R6: `rd_data` keeps the last word read until a new read is accepted. Writes and idle cycles leave it unchanged.
- R7: A command is accepted when `rdy_cnt` is at most PIPE_LVL-1 (at most 0 for levels 0 and 1). With PIPE_LVL=2, a read sent while `rdy_cnt` is 1 leaves the previous word readable in the next cycle, and the count shown in that next cycle is that of the new access.
- R8: A command sent while `rdy_cnt` is above the threshold, or with both strobes high at once, is ignored: no SRAM access, no change to memory or to the count. It sets `proto_err`, which stays set until reset.
- R9: `ram_dq_oe` is high only in cycles where `ram_we_n` is low, and never at the same time as a low `ram_oe_n`.
- R10: `ram_ce_n` is high in every cycle in which `rdy_cnt` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_rd | input | 1 | One-cycle read strobe |
| cmd_wr | input | 1 | One-cycle write strobe |
| cmd_addr | input | ADDR_W | Word address, valid with the strobe |
| cmd_wdata | input | 32 | Write word, valid with the strobe |
| rd_data | output | 32 | Last word read, held |
| rdy_cnt | output | 2 | Cycles left until completion, saturated at 3 |
| proto_err | output | 1 | Sticky flag for a command that broke the handshake rule |
| ram_addr | output | ADDR_W+1 | SRAM half-word address |
| ram_dq_o | output | 16 | Data driven toward the SRAM |
| ram_dq_i | input | 16 | Data coming from the SRAM |
| ram_dq_oe | output | 1 | Drive enable for the data pins |
| ram_ce_n | output | 1 | SRAM chip enable, active low |
| ram_oe_n | output | 1 | SRAM output enable, active low |
| ram_we_n | output | 1 | SRAM write strobe, active low |

## Verification
A wrong sequencer state has a visible effect at the ports. A wrong half counter makes the countdown skip or repeat a value in the next cycle, and it swaps halves or lands them at the wrong half-word address, which shows in `rd_data` or in the memory contents as soon as the access ends. A wrong pending-command state shows in the cycle right after an overlapped command: the count is wrong, or the old word is not readable. A broken drive-enable or strobe register shows in the same cycle as a clash between `ram_dq_oe` and a low `ram_oe_n`, or as a write that lands in the wrong place.

// File: rtl/sram16_word_slave.sv
module sram16_word_slave #(
  parameter int ADDR_W   = 18,
  parameter int WAIT_CYC = 1,
  parameter int PIPE_LVL = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_rd,
  input  logic              cmd_wr,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [31:0]       cmd_wdata,
  output logic [31:0]       rd_data,
  output logic [1:0]        rdy_cnt,
  output logic              proto_err,
  output logic [ADDR_W:0]   ram_addr,
  output logic [15:0]       ram_dq_o,
  input  logic [15:0]       ram_dq_i,
  output logic              ram_dq_oe,
  output logic              ram_ce_n,
  output logic              ram_oe_n,
  output logic              ram_we_n
);

  localparam int CW   = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam int THR  = (PIPE_LVL > 1) ? PIPE_LVL - 1 : 0;
  localparam int RLEN = 2 * WAIT_CYC;
  localparam int WLEN = 2 * WAIT_CYC + 1;
  localparam logic [CW-1:0] WLAST = CW'(WAIT_CYC - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_LO, PH_GAP, PH_HI} phase_t;

  phase_t              phase, n_phase;
  logic [CW-1:0]       wcnt, n_wcnt;
  logic                cur_wr, n_wr;
  logic [ADDR_W-1:0]   cur_addr, n_addr;
  logic [31:0]         cur_wdata, n_wdata;
  logic                pend_v, n_pv;
  logic                pend_wr, n_pwr;
  logic [ADDR_W-1:0]   pend_addr, n_paddr;
  logic [31:0]         pend_wdata, n_pwdata;

  int                  left, total;
  logic                half_last, free, accept, violate, n_act;

  assign half_last = (wcnt == WLAST);
  assign free      = (phase == PH_IDLE) || (phase == PH_HI && half_last);
  assign accept    = (cmd_rd ^ cmd_wr) && (rdy_cnt <= 2'(THR)) && !pend_v;
  assign violate   = (cmd_rd | cmd_wr) && !accept;

  always_comb begin
    case (phase)
      PH_LO:   left = (WAIT_CYC - int'(wcnt)) + (cur_wr ? 1 : 0) + WAIT_CYC;
      PH_GAP:  left = 1 + WAIT_CYC;
      PH_HI:   left = WAIT_CYC - int'(wcnt);
      default: left = 0;
    endcase
    total   = left + (pend_v ? (pend_wr ? WLEN : RLEN) : 0);
    rdy_cnt = (total >= 3) ? 2'd3 : 2'(total);
  end

  always_comb begin
    n_phase  = phase;
    n_wcnt   = wcnt;
    n_wr     = cur_wr;
    n_addr   = cur_addr;
    n_wdata  = cur_wdata;
    n_pv     = pend_v;
    n_pwr    = pend_wr;
    n_paddr  = pend_addr;
    n_pwdata = pend_wdata;
    case (phase)
      PH_LO:
        if (half_last) begin
          n_wcnt  = '0;
          n_phase = cur_wr ? PH_GAP : PH_HI;
        end else begin
          n_wcnt = wcnt + 1'b1;
        end
      PH_GAP: n_phase = PH_HI;
      PH_HI:
        if (half_last) begin
          n_wcnt  = '0;
          n_phase = PH_IDLE;
        end else begin
          n_wcnt = wcnt + 1'b1;
        end
      default: ;
    endcase
    if (free && pend_v) begin
      n_phase = PH_LO;
      n_wcnt  = '0;
      n_wr    = pend_wr;
      n_addr  = pend_addr;
      n_wdata = pend_wdata;
      n_pv    = 1'b0;
    end else if (free && accept) begin
      n_phase = PH_LO;
      n_wcnt  = '0;
      n_wr    = cmd_wr;
      n_addr  = cmd_addr;
      n_wdata = cmd_wdata;
    end else if (accept) begin
      n_pv     = 1'b1;
      n_pwr    = cmd_wr;
      n_paddr  = cmd_addr;
      n_pwdata = cmd_wdata;
    end
  end

  assign n_act = (n_phase == PH_LO) || (n_phase == PH_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      wcnt       <= '0;
      cur_wr     <= 1'b0;
      cur_addr   <= '0;
      cur_wdata  <= '0;
      pend_v     <= 1'b0;
      pend_wr    <= 1'b0;
      pend_addr  <= '0;
      pend_wdata <= '0;
      proto_err  <= 1'b0;
      rd_data    <= '0;
      ram_addr   <= '0;
      ram_dq_o   <= '0;
      ram_dq_oe  <= 1'b0;
      ram_ce_n   <= 1'b1;
      ram_oe_n   <= 1'b1;
      ram_we_n   <= 1'b1;
    end else begin
      phase      <= n_phase;
      wcnt       <= n_wcnt;
      cur_wr     <= n_wr;
      cur_addr   <= n_addr;
      cur_wdata  <= n_wdata;
      pend_v     <= n_pv;
      pend_wr    <= n_pwr;
      pend_addr  <= n_paddr;
      pend_wdata <= n_pwdata;
      proto_err  <= proto_err | violate;
      ram_ce_n   <= (n_phase == PH_IDLE);
      ram_oe_n   <= !(n_act && !n_wr);
      ram_we_n   <= !(n_act && n_wr);
      ram_dq_oe  <= n_act && n_wr;
      ram_addr   <= {n_addr, n_phase == PH_HI};
      ram_dq_o   <= (n_phase == PH_HI) ? n_wdata[31:16] : n_wdata[15:0];
      if (!cur_wr && half_last && phase == PH_LO) rd_data[15:0]  <= ram_dq_i;
      if (!cur_wr && half_last && phase == PH_HI) rd_data[31:16] <= ram_dq_i;
    end
  end

endmodule

// File: rtl/sram16_word_slave_chk.sv
module sram16_word_slave_chk #(
  parameter int PIPE_LVL = 2
) (
  input logic        clk,
  input logic        rst,
  input logic        cmd_rd,
  input logic        cmd_wr,
  input logic [31:0] rd_data,
  input logic [1:0]  rdy_cnt,
  input logic        proto_err,
  input logic        ram_dq_oe,
  input logic        ram_ce_n,
  input logic        ram_oe_n,
  input logic        ram_we_n
);
  localparam int THR = (PIPE_LVL > 1) ? PIPE_LVL - 1 : 0;

  // R9
  dq_drive_chk: assert property (@(posedge clk) disable iff (rst)
    ram_dq_oe |-> !ram_we_n);

  // R9
  bus_clash_chk: assert property (@(posedge clk) disable iff (rst)
    !(ram_dq_oe && !ram_oe_n));

  // R4
  rdy_step_chk: assert property (@(posedge clk) disable iff (rst)
    ((rdy_cnt == 2'd1 || rdy_cnt == 2'd2) && !cmd_rd && !cmd_wr) |=> rdy_cnt == $past(rdy_cnt) - 2'd1);

  // R4
  rdy_rest_chk: assert property (@(posedge clk) disable iff (rst)
    (rdy_cnt == 2'd0 && !cmd_rd && !cmd_wr) |=> rdy_cnt == 2'd0);

  // R6
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rdy_cnt == 2'd0 && !cmd_rd) |=> $stable(rd_data));

  // R8
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    ((cmd_rd || cmd_wr) && rdy_cnt > 2'(THR)) |=> proto_err);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);

  // R10
  ce_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (rdy_cnt == 2'd0) |-> ram_ce_n);
endmodule

bind sram16_word_slave sram16_word_slave_chk #(.PIPE_LVL(PIPE_LVL)) u_chk (
  .clk(clk), .rst(rst), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .rd_data(rd_data),
  .rdy_cnt(rdy_cnt), .proto_err(proto_err), .ram_dq_oe(ram_dq_oe),
  .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n)
);

// File: tb/sim_sram16_word_slave.sv
module sim_sram16_word_slave;
  localparam int AW   = 18;
  localparam int T    = 1;
  localparam int RLEN = 2 * T;
  localparam int WLEN = 2 * T + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_rd = 1'b0, cmd_wr = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [31:0]   cmd_wdata = '0;
  logic [31:0]   rd_data;
  logic [1:0]    rdy_cnt;
  logic          proto_err;
  logic [AW:0]   ram_addr;
  logic [15:0]   ram_dq_o, ram_dq_i;
  logic          ram_dq_oe, ram_ce_n, ram_oe_n, ram_we_n;

  int n_chk = 0, n_fail = 0, clash = 0, ce_bad = 0;
  bit done = 0;
  logic [15:0] mem [0:255];

  always #5 clk = ~clk;

  sram16_word_slave #(.ADDR_W(AW), .WAIT_CYC(T), .PIPE_LVL(2)) u0 (
    .clk(clk), .rst(rst), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .rd_data(rd_data), .rdy_cnt(rdy_cnt), .proto_err(proto_err),
    .ram_addr(ram_addr), .ram_dq_o(ram_dq_o), .ram_dq_i(ram_dq_i), .ram_dq_oe(ram_dq_oe),
    .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n));

  function automatic logic [15:0] fill(int i);
    return {8'(i) ^ 8'hA5, 8'(i)};
  endfunction

  function automatic logic [31:0] word(int a);
    return {fill(2 * a + 1), fill(2 * a)};
  endfunction

  function automatic logic [1:0] sat3(int v);
    return (v >= 3) ? 2'd3 : 2'(v);
  endfunction

  assign ram_dq_i = (!ram_ce_n && !ram_oe_n) ? mem[ram_addr[7:0]] : 16'hDEAD;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= fill(i);
    end else if (!ram_ce_n && !ram_we_n && ram_dq_oe) begin
      mem[ram_addr[7:0]] <= ram_dq_o;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (ram_dq_oe && (!ram_oe_n || ram_we_n)) clash++;
      if (rdy_cnt == 2'd0 && !ram_ce_n) ce_bad++;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(bit rd, bit wr, int a, logic [31:0] d);
    cmd_rd = rd; cmd_wr = wr; cmd_addr = AW'(a); cmd_wdata = d;
    @(negedge clk);
    cmd_rd = 0; cmd_wr = 0; cmd_addr = '1; cmd_wdata = 32'hBAD0_BAD0;
  endtask

  task automatic run_count(int len, int k0);
    for (int k = k0; k <= len; k++) begin
      chk(rdy_cnt == sat3(len - k), "R4 countdown", 32'(rdy_cnt), 32'(sat3(len - k)));
      if (k < len) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst = 1; cmd_rd = 0; cmd_wr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(rdy_cnt == 0, "R1 rdy", 32'(rdy_cnt), 0);
    chk(proto_err == 0, "R1 err", 32'(proto_err), 0);
    chk({ram_ce_n, ram_oe_n, ram_we_n, ram_dq_oe} == 4'b1110, "R1 pins",
        32'({ram_ce_n, ram_oe_n, ram_we_n, ram_dq_oe}), 32'hE);
  endtask

  task automatic t_read(int a, logic [31:0] exp, string tag);
    issue(1, 0, a, 32'h0);
    run_count(RLEN, 0);
    chk(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic t_write(int a, logic [31:0] d);
    int wlow = 0, gap = 0;
    issue(0, 1, a, d);
    for (int k = 0; k <= WLEN; k++) begin
      if (k < WLEN) begin
        if (!ram_ce_n && !ram_we_n) wlow++;
        if (!ram_ce_n && ram_we_n) gap++;
      end
      chk(rdy_cnt == sat3(WLEN - k), "R4 write countdown", 32'(rdy_cnt), 32'(sat3(WLEN - k)));
      if (k < WLEN) @(negedge clk);
    end
    @(negedge clk);
    chk(mem[8'(2 * a)] == d[15:0], "R3 low half", 32'(mem[8'(2 * a)]), 32'(d[15:0]));
    chk(mem[8'(2 * a + 1)] == d[31:16], "R3 high half", 32'(mem[8'(2 * a + 1)]), 32'(d[31:16]));
    chk(wlow == 2 * T, "R3 strobe cycles", 32'(wlow), 32'(2 * T));
    chk(gap == 1, "R3 gap cycle", 32'(gap), 1);
  endtask

  task automatic t_hold(int a, int b);
    t_read(a, word(a), "R2 before hold");
    t_write(b, 32'h1357_2468);
    chk(rd_data == word(a), "R6 after write", rd_data, word(a));
    repeat (5) @(negedge clk);
    chk(rd_data == word(a), "R6 after idle", rd_data, word(a));
  endtask

  task automatic t_pipe_rr(int a, int b);
    issue(1, 0, a, 32'h0);
    while (rdy_cnt != 2'd1) @(negedge clk);
    issue(1, 0, b, 32'h0);
    chk(rd_data == word(a), "R7 old word readable", rd_data, word(a));
    run_count(RLEN, 0);
    chk(rd_data == word(b), "R7 overlapped read", rd_data, word(b));
  endtask

  task automatic t_pipe_wr(int a, logic [31:0] d);
    issue(0, 1, a, d);
    while (rdy_cnt != 2'd1) @(negedge clk);
    issue(1, 0, a, 32'h0);
    run_count(RLEN, 0);
    chk(rd_data == d, "R7 read after overlapped write", rd_data, d);
  endtask

  task automatic t_violate(int a, int c);
    issue(1, 0, a, 32'h0);
    issue(0, 1, c, 32'hFFFF_FFFF);
    chk(proto_err == 1, "R8 flag set", 32'(proto_err), 1);
    chk(rdy_cnt == sat3(RLEN - 1), "R8 count unaffected", 32'(rdy_cnt), 32'(sat3(RLEN - 1)));
    run_count(RLEN, 1);
    chk(rd_data == word(a), "R8 current read intact", rd_data, word(a));
    t_read(c, word(c), "R8 ignored write left memory");
    chk(proto_err == 1, "R8 sticky", 32'(proto_err), 1);
  endtask

  task automatic t_both();
    t_reset();
    issue(1, 1, 7, 32'h0);
    chk(proto_err == 1, "R8 both strobes", 32'(proto_err), 1);
    chk(rdy_cnt == 0, "R8 both strobes no access", 32'(rdy_cnt), 0);
    chk(ram_ce_n == 1, "R8 both strobes chip idle", 32'(ram_ce_n), 1);
    chk(mem[14] == fill(14), "R8 both strobes memory", 32'(mem[14]), 32'(fill(14)));
  endtask

  initial begin
    t_reset();
    t_read(3, word(3), "R2 read");
    t_read(5, word(5), "R5 junk after strobe");
    t_write(20, 32'hCAFE_F00D);
    t_read(20, 32'hCAFE_F00D, "R3 readback");
    t_hold(11, 30);
    t_pipe_rr(40, 41);
    t_pipe_wr(50, 32'h0BAD_BEEF);
    t_violate(12, 9);
    t_both();
    chk(clash == 0, "R9 drive enable", 32'(clash), 0);
    chk(ce_bad == 0, "R10 chip enable idle", 32'(ce_bad), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule